// File: doc/BRIEF.md
# Asynchronous Parallel Flash Bus Front-End

This block sits on the device side of a parallel non-volatile memory. It takes the asynchronous bus pins: active-low chip select, write strobe, read strobe and address strobe, plus an output-inhibit pin, a reset/power-down pin, a 20-bit address and a 32-bit data path. It latches the address and command/write data for each bus cycle. It decides when the data bus may be driven. It also reports standby and power-down to the rest of the device. A fast internal clock samples every pin. A bus edge is seen as a change between two consecutive samples.

Captured words go onward on a command port. The port gives a one-cycle valid strobe with the word and its latched address, for a command decoder or a program/erase engine. The data bus is modelled as a driven value plus an output-enable. The `pwrDown` output tells the neighbouring status and configuration registers to clear.

Top module: `fbusFrontEnd`

## Requirements
- R1: After `rstN` is released, `dqOe` and `cmdValid` are 0, and `busReady` stays 0 until the recovery count has elapsed.
- R2: With `ceN` low, an address applied while `leN` is low is latched onto `cmdAddr` when `leN` rises, if `leN` is the first of `leN`, `weN`, `ceN` to rise.
- R3: If `weN` or `ceN` rises while `leN` is still low, that edge latches the address instead.
- R4: Each bus cycle latches the address at most once. Later rising edges leave `cmdAddr` unchanged until `leN` or `ceN` falls again.
- R5: With `ceN` and `weN` both low, the first rise of either one presents the data word on `cmdData`, the latched address on `cmdAddr`, and `cmdValid` high for exactly one clock.
- R6: A write is dropped, with no `cmdValid` pulse, if `oeN` was low or `odN` was high at any sample while `ceN` was low. Writes stay dropped until `ceN` has gone high.
- R7: `dqOe` is 1 only when the block is ready, `ceN`=0, `oeN`=0, `odN`=1 and `weN`=1. In that case `dqOut` equals `readData`; otherwise `dqOut` is 0.
- R8: `standby` is 1 when `ceN`=1, `peIdle`=1, `standbyDis`=0 and `rpN`=1. While `ceN` is high, `dqOe` is 0.
- R9: While `rpN` is low, `pwrDown` is 1, `busReady` and `dqOe` are 0, and no write is accepted.
- R10: After `rpN` returns high, `busReady` is 0 for `REC_CYCLES` further clocks and no command is accepted in that time. Then `busReady` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous chip reset, active low |
| rpN | input | 1 | Reset/power-down pin, active low |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Read strobe, active low |
| leN | input | 1 | Address strobe, active low |
| odN | input | 1 | Output inhibit, low forces the data bus off |
| addrIn | input | 20 | Address pins |
| dqIn | input | 32 | Data pins, inbound value |
| readData | input | 32 | Word supplied by the array for reads |
| peIdle | input | 1 | Program/erase engine is idle |
| standbyDis | input | 1 | Standby-disable configuration bit (bit 14 of the burst configuration word) |
| dqOut | output | 32 | Data pins, outbound value |
| dqOe | output | 1 | Data pins driven when 1 |
| cmdValid | output | 1 | One-cycle strobe for a captured word |
| cmdAddr | output | 20 | Latched address |
| cmdData | output | 32 | Captured command or write data |
| standby | output | 1 | Standby mode |
| pwrDown | output | 1 | Power-down mode; clears status and configuration registers |
| busReady | output | 1 | Bus operations accepted |

## Verification
Each pin is registered once. So `dqOe`, `dqOut`, `standby`, `pwrDown` and `busReady` follow a pin change one clock after it. A latched address or a `cmdValid` pulse appears two clocks after the rising edge that commits it: one clock to see the edge and one to register the capture. The bench drives pins on the falling clock edge and samples on a later falling edge at exactly that count. A separate monitor counts `cmdValid` pulses, so that a dropped or blocked write is seen as no new pulse after the cycle ends.

// File: rtl/fbus_pkg.sv
`timescale 1ns/1ps
package fbus_pkg;
  // strobes sent from control to datapath each clock
  typedef struct packed {
    logic capAddr;  // commit the address sampled one clock earlier
    logic capData;  // commit the data word sampled one clock earlier
    logic drive;    // drive the data bus from the array word
  } fbusStrobe_t;
endpackage

// File: rtl/fbusCtrl.sv
`timescale 1ns/1ps
module fbusCtrl
  import fbus_pkg::*;
#(
  parameter int REC_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rpN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic        leN,
  input  logic        odN,
  input  logic        peIdle,
  input  logic        standbyDis,
  output fbusStrobe_t strobe,
  output logic        standby,
  output logic        pwrDown,
  output logic        busReady
);
  localparam int CW = $clog2(REC_CYCLES + 2);

  // current sample (S) and previous sample (P) of the pins
  logic ceS, weS, oeS, leS, odS, rpS;
  logic ceP, weP, leP;
  logic [CW-1:0] recCnt;
  logic addrDone, badCycle, active;
  logic riseCe, riseWe, riseLe, fallCe, fallLe, violNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceS <= 1'b1; weS <= 1'b1; oeS <= 1'b1; leS <= 1'b1; odS <= 1'b0; rpS <= 1'b0;
      ceP <= 1'b1; weP <= 1'b1; leP <= 1'b1;
    end else begin
      ceS <= ceN; weS <= weN; oeS <= oeN; leS <= leN; odS <= odN; rpS <= rpN;
      ceP <= ceS; weP <= weS; leP <= leS;
    end
  end

  // recovery window after power-down release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recCnt <= CW'(REC_CYCLES);
    else if (!rpS) recCnt <= CW'(REC_CYCLES);
    else if (recCnt != '0) recCnt <= recCnt - CW'(1);
  end

  assign active  = rpS && (recCnt == '0);
  assign riseCe  = ceS && !ceP;
  assign riseWe  = weS && !weP;
  assign riseLe  = leS && !leP;
  assign fallCe  = !ceS && ceP;
  assign fallLe  = !leS && leP;
  assign violNow = !ceS && (!oeS || odS);

  always_comb begin
    strobe.capAddr = active && !leP && !ceP && !addrDone && (riseLe || riseWe || riseCe);
    strobe.capData = active && !weP && !ceP && !badCycle && (riseWe || riseCe);
    strobe.drive   = active && !ceS && !oeS && odS && weS;
  end

  // one address commit per cycle; a new cycle starts on a strobe fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrDone <= 1'b0;
    else if (!active || fallLe || fallCe) addrDone <= 1'b0;
    else if (strobe.capAddr) addrDone <= 1'b1;
  end

  // write qualification held until chip enable is released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) badCycle <= 1'b0;
    else if (!active || ceS) badCycle <= 1'b0;
    else if (violNow) badCycle <= 1'b1;
  end

  assign standby  = ceS && rpS && peIdle && !standbyDis;
  assign pwrDown  = !rpS;
  assign busReady = active;
endmodule

// File: rtl/fbusDatapath.sv
`timescale 1ns/1ps
module fbusDatapath
  import fbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  fbusStrobe_t   strobe,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dqIn,
  input  logic [DW-1:0] readData,
  output logic [DW-1:0] dqOut,
  output logic          dqOe,
  output logic          cmdValid,
  output logic [AW-1:0] cmdAddr,
  output logic [DW-1:0] cmdData
);
  logic [AW-1:0] addrS, addrP;
  logic [DW-1:0] dqS, dqP;

  // samples aligned with the control pin samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS <= '0; addrP <= '0; dqS <= '0; dqP <= '0;
    end else begin
      addrS <= addrIn; addrP <= addrS;
      dqS   <= dqIn;   dqP   <= dqS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAddr  <= '0;
      cmdData  <= '0;
      cmdValid <= 1'b0;
    end else begin
      if (strobe.capAddr) cmdAddr <= addrP;
      if (strobe.capData) cmdData <= dqP;
      cmdValid <= strobe.capData;
    end
  end

  assign dqOe  = strobe.drive;
  assign dqOut = strobe.drive ? readData : '0;
endmodule

// File: rtl/fbusFrontEnd.sv
`timescale 1ns/1ps
module fbusFrontEnd
  import fbus_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 32,
  parameter int REC_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rpN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic          leN,
  input  logic          odN,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dqIn,
  input  logic [DW-1:0] readData,
  input  logic          peIdle,
  input  logic          standbyDis,
  output logic [DW-1:0] dqOut,
  output logic          dqOe,
  output logic          cmdValid,
  output logic [AW-1:0] cmdAddr,
  output logic [DW-1:0] cmdData,
  output logic          standby,
  output logic          pwrDown,
  output logic          busReady
);
  fbusStrobe_t strobe;

  fbusCtrl #(.REC_CYCLES(REC_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .leN(leN), .odN(odN), .peIdle(peIdle), .standbyDis(standbyDis),
    .strobe(strobe), .standby(standby), .pwrDown(pwrDown), .busReady(busReady)
  );

  fbusDatapath #(.AW(AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn), .dqIn(dqIn),
    .readData(readData), .dqOut(dqOut), .dqOe(dqOe), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdData(cmdData)
  );
endmodule

// File: rtl/fbusFrontEndChk.sv
`timescale 1ns/1ps
module fbusFrontEndChk (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic weN,
  input logic oeN,
  input logic odN,
  input logic dqOe,
  input logic cmdValid,
  input logic standby,
  input logic pwrDown,
  input logic busReady
);
  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (!$past(ceN) && !$past(oeN) && $past(odN) && $past(weN))); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R5
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !dqOe); // R8
  AST_PD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> (!dqOe && !busReady)); // R9
  AST_NOT_READY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |=> !cmdValid); // R10
  AST_PD_THEN_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> !busReady); // R10
endmodule

bind fbusFrontEnd fbusFrontEndChk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .odN(odN),
  .dqOe(dqOe), .cmdValid(cmdValid), .standby(standby), .pwrDown(pwrDown),
  .busReady(busReady)
);

// File: tb/tb_fbusFrontEnd.sv
`timescale 1ns/1ps
module tb_fbusFrontEnd;
  localparam int REC = 8;
  logic clk = 1'b0, rstN = 1'b0;
  logic rpN = 1'b1, ceN = 1'b1, weN = 1'b1, oeN = 1'b1, leN = 1'b1, odN = 1'b0;
  logic [19:0] addrIn = '0;
  logic [31:0] dqIn = '0, readData = '0;
  logic peIdle = 1'b0, standbyDis = 1'b0;
  logic [31:0] dqOut, cmdData;
  logic [19:0] cmdAddr;
  logic dqOe, cmdValid, standby, pwrDown, busReady;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  fbusFrontEnd #(.REC_CYCLES(REC)) dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) if (rstN && cmdValid) pulses++;

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ceN = 1; weN = 1; oeN = 1; leN = 1; odN = 0; tick(); tick();
  endtask

  // mode 0: address strobe rises first; 1: write strobe first; 2: chip enable first
  task automatic doWrite(int mode, logic [19:0] a, logic [31:0] d,
                         output logic v1, output logic [19:0] ga,
                         output logic [31:0] gd, output logic v2);
    addrIn = a; dqIn = d; oeN = 1; odN = 0; leN = 0; ceN = 0;
    if (mode != 0) weN = 0;
    tick();
    if (mode == 0) begin
      leN = 1; tick(); weN = 0; tick(); tick(); weN = 1;
    end else begin
      tick();
      if (mode == 1) weN = 1; else ceN = 1;
    end
    tick(); tick();
    v1 = cmdValid; ga = cmdAddr; gd = cmdData;
    tick();
    v2 = cmdValid;
    idle();
  endtask

  initial begin
    logic v1, v2;
    logic [19:0] ga;
    logic [31:0] gd;
    int p0;
    tick(); tick();
    rstN = 1;
    check(dqOe == 0 && cmdValid == 0, "R1", "reset outputs", {dqOe, cmdValid}, 0);
    // R1/R10: busReady after exactly REC+1 clocks from release
    for (int n = 1; n <= REC + 1; n++) begin
      tick();
      check(busReady == (n == REC + 1), "R1", "recovery after reset", busReady, (n == REC + 1));
    end

    // R2 R3 R5: writes with each committing edge, arithmetic patterns
    for (int i = 0; i < 6; i++) begin
      logic [19:0] a;
      logic [31:0] d;
      a = 20'((i * 20'h1357 + 3) & 20'hFFFFF);
      d = 32'hA5A50000 ^ (i * 32'h01010101);
      doWrite(i % 3, a, d, v1, ga, gd, v2);
      check(ga == a, (i % 3 == 0) ? "R2" : "R3", "latched address", 32'(ga), 32'(a));
      check(v1 == 1 && gd == d, "R5", "data word with strobe", gd, d);
      check(v2 == 0, "R5", "strobe lasts one clock", v2, 0);
    end

    // R4: later edges in the same cycle do not recapture
    addrIn = 20'h11111; dqIn = 32'h0; leN = 0; ceN = 0; weN = 0; tick(); tick();
    weN = 1; tick();
    addrIn = 20'h22222; leN = 1; tick(); tick(); tick();
    check(cmdAddr == 20'h11111, "R4", "no second capture", 32'(cmdAddr), 32'h11111);
    leN = 0; tick(); tick(); leN = 1; tick(); tick();
    check(cmdAddr == 20'h22222, "R4", "new cycle after strobe fall", 32'(cmdAddr), 32'h22222);
    idle();

    // R6: read strobe low or inhibit high during the cycle drops the write
    for (int k = 0; k < 2; k++) begin
      p0 = pulses;
      ceN = 0; weN = 0; dqIn = 32'hDEAD0000 + k;
      if (k == 0) oeN = 0; else odN = 1;
      tick();
      oeN = 1; odN = 0; tick(); tick();
      weN = 1; tick(); tick(); tick();
      check(pulses == p0, "R6", "write dropped", pulses, p0);
      idle();
    end
    doWrite(1, 20'h0ABCD, 32'h600DF00D, v1, ga, gd, v2);
    check(v1 == 1 && gd == 32'h600DF00D, "R6", "write accepted after release", gd, 32'h600DF00D);

    // R7: sweep of ceN, oeN, odN, weN
    for (int v = 0; v < 16; v++) begin
      logic e;
      ceN = v[0]; oeN = v[1]; odN = v[2]; weN = v[3]; leN = 1;
      readData = 32'h10000000 + v * 32'h111;
      tick();
      e = !v[0] && !v[1] && v[2] && v[3];
      check(dqOe == e, "R7", "drive enable", dqOe, e);
      check(dqOut == (e ? readData : 32'h0), "R7", "data out", dqOut, e ? readData : 32'h0);
    end
    idle();

    // R8: standby sweep over ceN, peIdle, standbyDis with a read requested
    for (int v = 0; v < 8; v++) begin
      logic e;
      ceN = v[0]; peIdle = v[1]; standbyDis = v[2]; oeN = 0; odN = 1; weN = 1;
      tick();
      e = v[0] && v[1] && !v[2];
      check(standby == e, "R8", "standby", standby, e);
      if (v[0]) check(dqOe == 0, "R8", "quiet while deselected", dqOe, 0);
    end
    idle();

    // R9: power-down blocks reads and writes
    rpN = 0; ceN = 0; oeN = 0; odN = 1; weN = 1; tick();
    check(pwrDown == 1 && busReady == 0, "R9", "power-down flags", {pwrDown, busReady}, 2'b10);
    check(dqOe == 0, "R9", "bus off in power-down", dqOe, 0);
    oeN = 1; odN = 0; ceN = 1; tick();
    p0 = pulses;
    doWrite(1, 20'h00F0F, 32'h12345678, v1, ga, gd, v2);
    check(pulses == p0, "R9", "write blocked in power-down", pulses, p0);

    // R10: recovery window after release; reads and writes blocked inside it
    rpN = 1; ceN = 0; oeN = 0; odN = 1; weN = 1;
    for (int n = 1; n <= REC + 1; n++) begin
      tick();
      check(busReady == (n == REC + 1), "R10", "ready timing", busReady, (n == REC + 1));
      check(dqOe == (n == REC + 1), "R10", "read gated by recovery", dqOe, (n == REC + 1));
    end
    idle();
    rpN = 0; tick(); rpN = 1; tick();
    p0 = pulses;
    ceN = 0; weN = 0; tick(); weN = 1; tick(); tick(); tick();
    check(pulses == p0, "R10", "write blocked during recovery", pulses, p0);
    idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule